// File: doc/BRIEF.md
# Bit-Addressable Serial I/O Register Unit

This block gives a processor two bit spaces, one for input and one for output. Each holds 4096 bits, and each bit has its own 12-bit address. A command names a base bit address, a bit count from 1 to 16 and a direction. The unit then moves that run of bits between a CPU word and the addressed space, one bit per clock. Word bit 0 pairs with the base address, and later bits take consecutive addresses.

While a transfer runs, the unit drives a one-hot set of module-select lines. Each line stands for one device slot covering 32 consecutive bit addresses, so a device decodes only the low address bits. The device side is modelled inside the block:
- A device port writes single bits of the input space.
- The same port reads single bits of the output space.

Top module: `bitio_unit`

## Requirements
- R1: After reset, busy, done, rdata and mod_sel are all zero, and every bit of both spaces reads 0.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. A cmd_valid seen while busy is high is ignored and changes no output and no space bit.
- R3: cmd_count values 1 to 15 move that many bits and the value 0 moves 16 bits. busy is high for exactly that many cycles, starting in the cycle after acceptance.
- R4: done is high for exactly one cycle, the first cycle after the last bit, and busy is low in that cycle.
- R5: A write (cmd_write=1) stores cmd_wdata bit i into output-space address base+i for i below the count. Every other output bit keeps its value.
- R6: A read (cmd_write=0) returns input-space bit base+i in rdata bit i. rdata bits at and above the count are 0. rdata is cleared when a command is accepted, is valid while done is high, and then holds until the next accepted command.
- R7: Addresses above 4095 inside a run wrap to 0.
- R8: While busy, exactly one mod_sel line is high, and its index is bus_addr[11:5]. While idle, all mod_sel lines are low.
- R9: bus_addr equals the base address in the first busy cycle and rises by one (mod 4096) in each later busy cycle.
- R10: When dev_wr is high at a clock edge, input-space bit dev_addr takes dev_wbit. dev_rbit shows output-space bit dev_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write output space, 0 = read input space |
| cmd_addr | input | 12 | Base bit address |
| cmd_count | input | 4 | Bit count, 0 meaning 16 |
| cmd_wdata | input | 16 | Word to write, bit 0 at the base |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |
| bus_addr | output | 12 | Bit address moved this cycle |
| mod_sel | output | 128 | One-hot slot select, 32 bits per slot |
| dev_wr | input | 1 | Device write strobe to input space |
| dev_addr | input | 12 | Device-side bit address |
| dev_wbit | input | 1 | Bit written by the device |
| dev_rbit | output | 1 | Output-space bit at dev_addr |

## Verification
Random bases, counts and data are applied in both directions against bench models of the two spaces:
- Runs of varied length show whether the count decode, the bit ordering and the zero fill of rdata are right.
- Bases chosen next to 4095 and next to 32-bit slot boundaries show whether the address wraps and whether mod_sel changes lines mid-run.
- After each write, the bits just before and just after the run are read back, which shows whether the write spills outside its range.
- A directed case issues a command while busy, to show that it is ignored.
- Directed cases use count 0 and count 1, the two ends of the count range.

// File: rtl/bitio_pkg.sv
// Package: shared defaults and the transfer direction type for the
// bit-addressable I/O unit. Assumes nothing beyond IEEE 1800-2017.
package bitio_pkg;
    localparam int DEF_ADDR_W = 12;  // bits of bit address
    localparam int DEF_WORD_W = 16;  // CPU word width, power of two
    localparam int DEF_BLK_W  = 5;   // address bits decoded inside a slot

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;
endpackage

// File: rtl/bitio_space.sv
// Module: one bit space of DEPTH single bits with one synchronous write
// port and one combinational read port. Assumes DEPTH = 2**AW.
module bitio_space #(
    parameter int AW = 12,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr,
    output logic          rbit
);
    logic [DEPTH-1:0] bits_q;

    // Purpose: clear all bits on reset, then store one bit per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q[waddr] <= wbit;
        end
    end

    // Purpose: the read port is a plain bit select.
    assign rbit = bits_q[raddr];
endmodule

// File: rtl/bitio_seq.sv
// Module: the transfer sequencer. It accepts a command when idle, then
// steps a bit address and a word index once per clock for the given
// count (0 meaning WORD_W bits). It raises done for one cycle after the
// last bit. Assumes WORD_W is a power of two, so that count-1 wraps 0
// to the last index.
module bitio_seq #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  idx
);
    logic              busy_q, done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q, last_q;

    // Purpose: a command is taken only while no transfer runs.
    assign accept = start && !busy_q;

    // Purpose: load the run on accept, then step address and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            addr_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                addr_q <= base;
                idx_q  <= '0;
                last_q <= count - CNT_W'(1);
            end else if (busy_q) begin
                if (idx_q == last_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q  <= idx_q + CNT_W'(1);
                    addr_q <= addr_q + ADDR_W'(1);
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign addr = addr_q;
    assign idx  = idx_q;
endmodule

// File: rtl/bitio_decode.sv
// Module: partial address decode into one select line per slot. Each
// slot covers 2**BLK_W bit addresses. All lines stay low when the
// enable is low.
module bitio_decode #(
    parameter int ADDR_W = 12,
    parameter int BLK_W  = 5,
    localparam int NUM_SEL = 1 << (ADDR_W - BLK_W)
) (
    input  logic               en,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SEL-1:0] sel
);
    logic [ADDR_W-BLK_W-1:0] slot;

    // Purpose: only the upper address bits pick the slot.
    assign slot = addr[ADDR_W-1:BLK_W];

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        // Purpose: one comparator per slot line.
        assign sel[g] = en && (slot == (ADDR_W-BLK_W)'(g));
    end
endmodule

// File: rtl/bitio_unit.sv
// Module: top of the bit-addressable serial I/O unit. It joins the
// sequencer, the slot decoder and the two bit spaces, and holds the
// command word and the read result. Assumes a synchronous active-low
// reset and a single clock.
module bitio_unit #(
    parameter int ADDR_W = bitio_pkg::DEF_ADDR_W,
    parameter int WORD_W = bitio_pkg::DEF_WORD_W,
    parameter int BLK_W  = bitio_pkg::DEF_BLK_W,
    localparam int CNT_W   = $clog2(WORD_W),
    localparam int NUM_SEL = 1 << (ADDR_W - BLK_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [CNT_W-1:0]   cmd_count,
    input  logic [WORD_W-1:0]  cmd_wdata,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  rdata,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [NUM_SEL-1:0] mod_sel,
    input  logic               dev_wr,
    input  logic [ADDR_W-1:0]  dev_addr,
    input  logic               dev_wbit,
    output logic               dev_rbit
);
    import bitio_pkg::*;

    logic              accept, busy_w, in_bit;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_idx;
    dir_e              dir_q;
    logic [WORD_W-1:0] wdata_q, rdata_q;

    bitio_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cmd_valid),
        .base   (cmd_addr),
        .count  (cmd_count),
        .accept (accept),
        .busy   (busy_w),
        .done   (done),
        .addr   (cur_addr),
        .idx    (cur_idx)
    );

    bitio_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
        .en   (busy_w),
        .addr (cur_addr),
        .sel  (mod_sel)
    );

    // Input space: the device writes it, the sequencer reads it.
    bitio_space #(.AW(ADDR_W)) u_in_space (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dev_wr),
        .waddr (dev_addr),
        .wbit  (dev_wbit),
        .raddr (cur_addr),
        .rbit  (in_bit)
    );

    // Output space: the sequencer writes it, the device reads it.
    bitio_space #(.AW(ADDR_W)) u_out_space (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (busy_w && (dir_q == DIR_WRITE)),
        .waddr (cur_addr),
        .wbit  (wdata_q[cur_idx]),
        .raddr (dev_addr),
        .rbit  (dev_rbit)
    );

    // Purpose: latch direction and write word when a command is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= DIR_READ;
            wdata_q <= '0;
        end else if (accept) begin
            dir_q   <= cmd_write ? DIR_WRITE : DIR_READ;
            wdata_q <= cmd_wdata;
        end
    end

    // Purpose: clear the result on accept, then gather read bits by index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= '0;
        end else if (busy_w && (dir_q == DIR_READ)) begin
            rdata_q[cur_idx] <= in_bit;
        end
    end

    assign busy     = busy_w;
    assign rdata    = rdata_q;
    assign bus_addr = cur_addr;
endmodule

// File: rtl/bitio_unit_chk.sv
// Module: protocol checker for bitio_unit, attached by bind. It watches
// only the top-level ports.
module bitio_unit_chk #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    parameter int BLK_W  = 5,
    localparam int NUM_SEL = 1 << (ADDR_W - BLK_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               busy,
    input logic               done,
    input logic [WORD_W-1:0]  rdata,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SEL-1:0] mod_sel
);
    assert_cmd_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> $stable(rdata));

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (bus_addr == ADDR_W'($past(bus_addr) + 1'b1)));

    assert_sel_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (($countones(mod_sel) == 1) && mod_sel[bus_addr[ADDR_W-1:BLK_W]]));

    assert_sel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mod_sel == '0));
endmodule

bind bitio_unit bitio_unit_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .BLK_W  (BLK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .bus_addr  (bus_addr),
    .mod_sel   (mod_sel)
);

// File: tb/tb_bitio_unit.sv
module tb_bitio_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [11:0]  cmd_addr = '0;
    logic [3:0]   cmd_count = '0;
    logic [15:0]  cmd_wdata = '0;
    logic         busy, done, dev_rbit;
    logic [15:0]  rdata;
    logic [11:0]  bus_addr;
    logic [127:0] mod_sel;
    logic         dev_wr = 1'b0, dev_wbit = 1'b0;
    logic [11:0]  dev_addr = '0;

    int vectors = 0;
    int fails = 0;
    bit in_m [4096];
    bit out_m[4096];

    bitio_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .mod_sel(mod_sel), .dev_wr(dev_wr), .dev_addr(dev_addr),
        .dev_wbit(dev_wbit), .dev_rbit(dev_rbit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int run_len(input logic [3:0] c);
        return (c == 4'd0) ? 16 : int'(c);
    endfunction

    function automatic logic [15:0] exp_read(input logic [11:0] base, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = in_m[12'(base + 12'(i))];
        return r;
    endfunction

    function automatic logic [127:0] exp_sel(input logic [11:0] a);
        return 128'(1) << a[11:5];
    endfunction

    task automatic dev_set(input logic [11:0] a, input bit b);
        @(negedge clk);
        dev_wr = 1'b1; dev_addr = a; dev_wbit = b;
        @(negedge clk);
        dev_wr = 1'b0;
        in_m[a] = b;
    endtask

    // Read one output-space bit through the device port and compare (R10).
    task automatic peek_out(input logic [11:0] a, input string req);
        dev_addr = a;
        #1;
        chk(req, 32'(dev_rbit), 32'(out_m[a]));
    endtask

    task automatic run_cmd(input bit wr, input logic [11:0] base,
                           input logic [3:0] cnt, input logic [15:0] wd,
                           input bit inject);
        int n = run_len(cnt);
        logic [15:0] er;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = base;
        cmd_count = cnt; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [11:0] a = 12'(base + 12'(k));
            chk("R3 busy during run", 32'(busy), 32'd1);
            chk("R9 R7 bus_addr step", 32'(bus_addr), 32'(a));
            chk("R8 slot select", 32'(mod_sel === exp_sel(a)), 32'd1);
            if (inject && k == 0) begin
                // R2: request while busy, must be ignored
                cmd_valid = 1'b1; cmd_write = 1'b1;
                cmd_addr = base ^ 12'h800; cmd_count = 4'd0; cmd_wdata = 16'hFFFF;
            end
            if (inject && k == 1) cmd_valid = 1'b0;
            @(negedge clk);
        end
        if (wr) for (int i = 0; i < n; i++) out_m[12'(base + 12'(i))] = wd[i];
        chk("R3 busy falls after count", 32'(busy), 32'd0);
        chk("R4 done pulse", 32'(done), 32'd1);
        chk("R8 idle select", 32'(mod_sel === '0), 32'd1);
        er = exp_read(base, n);
        if (!wr) chk("R6 read result", 32'(rdata), 32'(er));
        if (wr) chk("R6 rdata zero after write", 32'(rdata), 32'd0);
        @(negedge clk);
        chk("R4 done one cycle", 32'(done), 32'd0);
        if (!wr) chk("R6 rdata held", 32'(rdata), 32'(er));
        if (wr) begin
            peek_out(12'(base - 12'd1), "R5 below run untouched");
            peek_out(base, "R5 first bit");
            peek_out(12'(base + 12'(n - 1)), "R5 R7 last bit");
            peek_out(12'(base + 12'(n)), "R5 above run untouched");
        end
        if (inject) begin
            chk("R2 no restart", 32'(busy), 32'd0);
            peek_out(base ^ 12'h800, "R2 ignored write");
            peek_out(12'((base ^ 12'h800) + 12'd3), "R2 ignored write");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 rdata", 32'(rdata), 32'd0);
        chk("R1 mod_sel", 32'(mod_sel === '0), 32'd1);
        peek_out(12'd0, "R1 out space");
        peek_out(12'd4095, "R1 out space");
        run_cmd(1'b0, 12'd100, 4'd0, 16'h0, 1'b0);  // R1 input space reads 0

        // Directed corners
        dev_set(12'd4095, 1'b1);
        dev_set(12'd0, 1'b1);
        dev_set(12'd2, 1'b1);
        run_cmd(1'b0, 12'd4090, 4'd0, 16'h0, 1'b0);  // R7 wrap, 16 bits
        run_cmd(1'b0, 12'd4095, 4'd2, 16'h0, 1'b0);  // R7 two bits across 0
        run_cmd(1'b0, 12'd2, 4'd1, 16'h0, 1'b0);     // R3 single bit
        run_cmd(1'b1, 12'd4088, 4'd0, 16'hA5C3, 1'b0);
        run_cmd(1'b1, 12'd31, 4'd1, 16'h0001, 1'b0);
        run_cmd(1'b1, 12'd30, 4'd5, 16'h0015, 1'b1); // R2 injected request
        run_cmd(1'b0, 12'd1, 4'd3, 16'h0, 1'b1);     // R2 injected on a read

        // Random mix
        for (int t = 0; t < 250; t++) begin
            logic [11:0] base;
            logic [3:0]  cnt;
            bit wr;
            base = 12'($urandom);
            if ($urandom_range(0, 4) == 0) base = 12'(4096 - $urandom_range(1, 16));
            if ($urandom_range(0, 4) == 0) base = {base[11:5], 5'(32 - $urandom_range(1, 8))};
            cnt = 4'($urandom);
            wr  = $urandom_range(0, 1) == 1;
            if (!wr) for (int j = 0; j < 6; j++)
                dev_set(12'(base + 12'($urandom_range(0, 15))), $urandom_range(0, 1) == 1);
            run_cmd(wr, base, cnt, 16'($urandom), $urandom_range(0, 9) == 0 && cnt != 4'd1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule